// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Scheduler

This block handles the SDRAM's upkeep commands, so that the main command path only has to arbitrate and drive pins. After reset it keeps the clock enable high and the data mask asserted for a stabilisation wait. It then requests a precharge of every bank, a fixed number of auto-refresh commands and a mode-register load, in that order. Each request waits for a grant from the command path. After each granted command the block inserts a programmable number of idle cycles before it raises the next request.

Once the power-up sequence ends, a free-running interval counter adds one unit of refresh debt per refresh period. The period is derived from the clock rate, the retention window and the number of rows. While the debt is non-zero, the block requests auto-refreshes back to back and asks the command path to defer normal traffic. It first requests a precharge-all whenever the bank-idle indication is low. The block also enters self-refresh on request. It lowers the clock enable for as long as the request stays high. On exit it holds off every command for a recovery window and then restarts the refresh timing from zero.

Top module: `sdram_upkeep_sched`

## Requirements
- R1: During reset, `cke` = 1, `dqm_hold` = 1, `traffic_hold` = 1, `init_done` = 0 and `req_valid` = 0.
- R2: The first request is a precharge-all. It appears in the cycle that is STABLE_US×CLK_MHZ cycles after reset is released, and no request appears before it.
- R3: The power-up sequence is a precharge-all, then INIT_REFS auto-refreshes, then a mode-register load. Command codes on `req_cmd` are: 0 idle, 1 precharge-all, 2 auto-refresh, 3 mode-register load, 4 self-refresh entry. Precharge-all drives address bit 10 high. Auto-refresh drives address zero. Mode-register load drives MODE_WORD.
- R4: A request stays asserted until it is granted. When grants are immediate, the next request comes exactly T+1 cycles after the granted one, where T is T_RP after a precharge-all, T_RC after an auto-refresh and T_MRD after a mode-register load.
- R5: `init_done` rises and `dqm_hold` falls T_MRD+1 cycles after the mode-register load is granted. Both then keep those values.
- R6: Let INTERVAL = CLK_MHZ×REF_WINDOW_US/REF_ROWS. The first run-time refresh request comes INTERVAL cycles after `init_done` rises, and later refreshes follow every INTERVAL cycles when nothing delays them.
- R7: `traffic_hold` is low only when the block is in normal running, owes no refresh and has no self-refresh request. After an immediately granted refresh it stays high for T_RC more cycles.
- R8: An auto-refresh is requested only while `all_idle` is high. When a refresh is owed while `all_idle` is low, a precharge-all is requested first, and the refresh follows T_RP+1 cycles after its grant.
- R9: Refresh debt grows by one per interval and saturates at 2^DEBT_W−1. Owed refreshes are served back to back, T_RC+1 cycles apart. Once the debt is cleared, the number of refreshes served equals the number of intervals that have elapsed.
- R10: In normal running with no debt, a high `self_req` raises a self-refresh entry request. `cke` goes low in the cycle after its grant and stays low, with no request, while `self_req` stays high.
- R11: In the cycle after `self_req` falls, `cke` rises. For T_XSR cycles no request is made and `traffic_hold` stays high. The next refresh is due INTERVAL cycles after that window.
- R12: A self-refresh request made while `all_idle` is low is preceded by a precharge-all. The entry request comes T_RP+1 cycles after the precharge-all is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| all_idle | input | 1 | High when every bank is precharged |
| self_req | input | 1 | Level request to stay in self-refresh |
| req_grant | input | 1 | Command path accepts the pending request this cycle |
| req_valid | output | 1 | An upkeep command is requested |
| req_cmd | output | 3 | Requested command code (see R3) |
| req_addr | output | ADDR_W | Address to drive with the command |
| cke | output | 1 | Clock-enable level for the device |
| dqm_hold | output | 1 | Keep the data mask asserted (power-up) |
| init_done | output | 1 | Power-up sequence complete |
| traffic_hold | output | 1 | Normal traffic must be deferred |

## Verification
Every result is tied to a known number of cycles after the event that causes it. The first precharge-all lands exactly the stabilisation count after reset release. Each follow-on request lands gap+1 cycles after the grant before it. A refresh lands a whole number of intervals after `init_done` rises or after the self-refresh recovery window ends. `cke` moves one cycle after the entry grant or after `self_req` falls. The bench stamps every granted command with the cycle in which it was granted and compares those stamps with the arithmetic offsets. It reads level outputs only at the negative edge of the exact cycle computed for them. For the debt sweep it waits until `traffic_hold` has dropped and then compares the number of refreshes served with the number of elapsed intervals.

// File: rtl/upk_pkg.sv
package upk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_AREF = 3'd2,
        CMD_MRS  = 3'd3,
        CMD_SREF = 3'd4
    } upk_cmd_e;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_IPALL,
        ST_IREF,
        ST_IMRS,
        ST_WAIT,
        ST_RUN,
        ST_SELF,
        ST_EXIT
    } upk_state_e;

    typedef struct packed {
        logic     valid;
        upk_cmd_e cmd;
    } upk_req_t;

    // bits needed to hold the value v (at least one)
    function automatic int unsigned upk_bits(input int unsigned v);
        int unsigned b;
        b = $clog2(v + 1);
        return (b == 0) ? 1 : b;
    endfunction

    function automatic int unsigned upk_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/upk_gap_timer.sv
module upk_gap_timer #(
    parameter int unsigned W         = 8,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RESET_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1))); // R4

    AST_GAP_LOADED: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))); // R4

endmodule

// File: rtl/upk_refresh_debt.sv
module upk_refresh_debt #(
    parameter int unsigned INTERVAL = 2078,
    parameter int unsigned DEBT_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              consume,
    output logic [DEBT_W-1:0] debt
);
    import upk_pkg::*;

    localparam int unsigned IW = upk_bits(INTERVAL);
    localparam logic [IW-1:0]     LAST     = IW'(INTERVAL - 1);
    localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};

    logic [IW-1:0] phase;
    logic          tick;
    logic          full;
    logic          grow;

    assign tick = run_en && (phase == LAST);
    assign full = (debt == DEBT_MAX);
    assign grow = tick && (!full || consume);

    always_ff @(posedge clk) begin
        if (rst || !run_en)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en)
            debt <= '0;
        else if (grow && !consume)
            debt <= debt + 1'b1;
        else if (!grow && consume)
            debt <= debt - 1'b1;
    end

    AST_DEBT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (run_en && full && !consume) |=> (debt == DEBT_MAX)); // R9

    AST_DEBT_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
        (run_en && !consume) |=> (debt >= $past(debt))); // R9

    AST_CONSUME_OWED: assert property (@(posedge clk) disable iff (rst)
        consume |-> (debt != '0)); // R9

endmodule

// File: rtl/upk_seq.sv
module upk_seq #(
    parameter int unsigned ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
    parameter int unsigned INIT_REFS  = 8,
    parameter int unsigned TMR_W      = 16,
    parameter int unsigned DEBT_W     = 4,
    parameter int unsigned T_RP       = 3,
    parameter int unsigned T_RC       = 9,
    parameter int unsigned T_MRD      = 2,
    parameter int unsigned T_XSR      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              all_idle,
    input  logic              self_req,
    input  logic              grant,
    input  logic [DEBT_W-1:0] debt,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              consume,
    output logic              run_en,
    output logic              req_valid,
    output logic [2:0]        req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic              cke,
    output logic              dqm_hold,
    output logic              init_done,
    output logic              traffic_hold
);
    import upk_pkg::*;

    localparam int unsigned IRW       = upk_bits(INIT_REFS);
    localparam logic [IRW-1:0] IREF_LAST = IRW'(INIT_REFS - 1);
    localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP - 1);
    localparam logic [TMR_W-1:0] LD_RC  = TMR_W'(T_RC - 1);
    localparam logic [TMR_W-1:0] LD_MRD = TMR_W'(T_MRD - 1);
    localparam logic [TMR_W-1:0] LD_XSR = TMR_W'(T_XSR - 1);
    localparam int unsigned PALL_BIT = 10;

    upk_state_e     state, nxt, ret_q, nxt_ret;
    logic           done_q, done_set;
    logic [IRW-1:0] iref_q;
    logic           iref_inc;
    upk_req_t       req;
    logic [ADDR_W-1:0] pall_addr;

    generate
        if (ADDR_W > PALL_BIT) begin : g_a10
            assign pall_addr = ADDR_W'(1) << PALL_BIT;
        end else begin : g_no_a10
            assign pall_addr = '0;
        end
    endgenerate

    always_comb begin
        nxt      = state;
        nxt_ret  = ret_q;
        req      = '{valid: 1'b0, cmd: CMD_NOP};
        tmr_load = 1'b0;
        tmr_val  = '0;
        consume  = 1'b0;
        done_set = 1'b0;
        iref_inc = 1'b0;
        unique case (state)
            ST_STABLE: if (tmr_zero) nxt = ST_IPALL;
            ST_IPALL: begin
                req = '{valid: 1'b1, cmd: CMD_PALL};
                if (grant) begin
                    tmr_load = 1'b1; tmr_val = LD_RP;
                    nxt_ret  = ST_IREF; nxt = ST_WAIT;
                end
            end
            ST_IREF: begin
                req = '{valid: 1'b1, cmd: CMD_AREF};
                if (grant) begin
                    tmr_load = 1'b1; tmr_val = LD_RC;
                    iref_inc = 1'b1;
                    nxt_ret  = (iref_q == IREF_LAST) ? ST_IMRS : ST_IREF;
                    nxt      = ST_WAIT;
                end
            end
            ST_IMRS: begin
                req = '{valid: 1'b1, cmd: CMD_MRS};
                if (grant) begin
                    tmr_load = 1'b1; tmr_val = LD_MRD;
                    nxt_ret  = ST_RUN; nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    nxt = ret_q;
                    if (ret_q == ST_RUN) done_set = 1'b1;
                end
            end
            ST_RUN: begin
                if (debt != '0)
                    req = '{valid: 1'b1, cmd: all_idle ? CMD_AREF : CMD_PALL};
                else if (self_req)
                    req = '{valid: 1'b1, cmd: all_idle ? CMD_SREF : CMD_PALL};
                if (req.valid && grant) begin
                    unique case (req.cmd)
                        CMD_AREF: begin
                            consume  = 1'b1;
                            tmr_load = 1'b1; tmr_val = LD_RC;
                            nxt_ret  = ST_RUN; nxt = ST_WAIT;
                        end
                        CMD_SREF: nxt = ST_SELF;
                        default: begin
                            tmr_load = 1'b1; tmr_val = LD_RP;
                            nxt_ret  = ST_RUN; nxt = ST_WAIT;
                        end
                    endcase
                end
            end
            ST_SELF: begin
                if (!self_req) begin
                    tmr_load = 1'b1; tmr_val = LD_XSR;
                    nxt = ST_EXIT;
                end
            end
            ST_EXIT: if (tmr_zero) nxt = ST_RUN;
            default: nxt = ST_STABLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_STABLE;
            ret_q  <= ST_IREF;
            done_q <= 1'b0;
            iref_q <= '0;
        end else begin
            state <= nxt;
            ret_q <= nxt_ret;
            if (done_set) done_q <= 1'b1;
            if (iref_inc) iref_q <= iref_q + 1'b1;
        end
    end

    always_comb begin
        unique case (req.cmd)
            CMD_PALL: req_addr = pall_addr;
            CMD_MRS:  req_addr = MODE_WORD;
            default:  req_addr = '0;
        endcase
    end

    assign req_valid    = req.valid;
    assign req_cmd      = req.cmd;
    assign cke          = (state != ST_SELF);
    assign dqm_hold     = !done_q;
    assign init_done    = done_q;
    assign run_en       = done_q && (state != ST_SELF) && (state != ST_EXIT);
    assign traffic_hold = !((state == ST_RUN) && (debt == '0) && !self_req);

    AST_INIT_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !grant && !init_done) |=> (req_valid && $stable(req_cmd))); // R4

    AST_REFRESH_BANKS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_cmd == CMD_AREF || req_cmd == CMD_SREF)) |-> all_idle); // R8

    AST_HOLD_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> traffic_hold); // R7

    AST_SELF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !cke |-> !req_valid); // R10

    AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (!req_valid && traffic_hold)); // R11

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !dqm_hold)); // R5

endmodule

// File: rtl/sdram_upkeep_sched.sv
module sdram_upkeep_sched #(
    parameter int unsigned CLK_MHZ       = 133,
    parameter int unsigned REF_WINDOW_US = 64000,
    parameter int unsigned REF_ROWS      = 4096,
    parameter int unsigned STABLE_US     = 200,
    parameter int unsigned INIT_REFS     = 8,
    parameter int unsigned T_RP          = 3,
    parameter int unsigned T_RC          = 9,
    parameter int unsigned T_MRD         = 2,
    parameter int unsigned T_XSR         = 10,
    parameter int unsigned DEBT_W        = 4,
    parameter int unsigned ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h032
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              all_idle,
    input  logic              self_req,
    input  logic              req_grant,
    output logic              req_valid,
    output logic [2:0]        req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic              cke,
    output logic              dqm_hold,
    output logic              init_done,
    output logic              traffic_hold
);
    import upk_pkg::*;

    localparam int unsigned INTERVAL   = CLK_MHZ * REF_WINDOW_US / REF_ROWS;
    localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int unsigned GAP_MAX    = upk_max(upk_max(T_RP, T_RC), upk_max(T_MRD, T_XSR));
    localparam int unsigned TMR_W      = upk_bits(upk_max(STABLE_CYC, GAP_MAX));

    logic              tmr_load, tmr_zero, consume, run_en;
    logic [TMR_W-1:0]  tmr_val;
    logic [DEBT_W-1:0] debt;

    upk_gap_timer #(
        .W         (TMR_W),
        .RESET_VAL (STABLE_CYC - 1)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    upk_refresh_debt #(
        .INTERVAL (INTERVAL),
        .DEBT_W   (DEBT_W)
    ) i_debt (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .consume (consume),
        .debt    (debt)
    );

    upk_seq #(
        .ADDR_W    (ADDR_W),
        .MODE_WORD (MODE_WORD),
        .INIT_REFS (INIT_REFS),
        .TMR_W     (TMR_W),
        .DEBT_W    (DEBT_W),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .T_MRD     (T_MRD),
        .T_XSR     (T_XSR)
    ) i_seq (
        .clk          (clk),
        .rst          (rst),
        .all_idle     (all_idle),
        .self_req     (self_req),
        .grant        (req_grant),
        .debt         (debt),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .consume      (consume),
        .run_en       (run_en),
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .req_addr     (req_addr),
        .cke          (cke),
        .dqm_hold     (dqm_hold),
        .init_done    (init_done),
        .traffic_hold (traffic_hold)
    );

endmodule

// File: tb/test_sdram_upkeep_sched.sv
`timescale 1ns/1ps
module test_sdram_upkeep_sched;

    localparam int CLK_MHZ = 1, WIN_US = 640, ROWS = 16, STAB_US = 12, IREFS = 3;
    localparam int T_RP = 2, T_RC = 3, T_MRD = 2, T_XSR = 4, DEBT_W = 3, ADDR_W = 12;
    localparam logic [11:0] MODE = 12'h032;
    localparam int INTERVAL = CLK_MHZ * WIN_US / ROWS;
    localparam int STAB = CLK_MHZ * STAB_US;
    localparam logic [2:0] C_PALL = 3'd1, C_AREF = 3'd2, C_MRS = 3'd3, C_SREF = 3'd4;

    logic clk = 1'b0, rst = 1'b1, all_idle = 1'b0, self_req = 1'b0, busy = 1'b0;
    logic req_grant, req_valid, cke, dqm_hold, init_done, traffic_hold;
    logic [2:0] req_cmd;
    logic [ADDR_W-1:0] req_addr;

    int cyc = 0, tests = 0, fails = 0, nlog = 0;
    int lcyc [256];
    logic [2:0] lcmd [256];
    logic [11:0] laddr [256];

    assign req_grant = req_valid & ~busy;

    sdram_upkeep_sched #(
        .CLK_MHZ(CLK_MHZ), .REF_WINDOW_US(WIN_US), .REF_ROWS(ROWS), .STABLE_US(STAB_US),
        .INIT_REFS(IREFS), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .T_XSR(T_XSR),
        .DEBT_W(DEBT_W), .ADDR_W(ADDR_W), .MODE_WORD(MODE)
    ) i_sdram_upkeep_sched (
        .clk(clk), .rst(rst), .all_idle(all_idle), .self_req(self_req), .req_grant(req_grant),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .cke(cke),
        .dqm_hold(dqm_hold), .init_done(init_done), .traffic_hold(traffic_hold)
    );

    always #2.5 clk = ~clk;

    // grant logger: stamps each accepted command with its cycle
    always @(posedge clk) begin
        if (!rst) begin
            if (req_valid && req_grant && nlog < 256) begin
                lcyc[nlog]  <= cyc;
                lcmd[nlog]  <= req_cmd;
                laddr[nlog] <= req_addr;
                nlog        <= nlog + 1;
                if (req_cmd == C_PALL) all_idle <= 1'b1;
            end
            cyc <= cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic upto(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic until_log(input int n);
        while (nlog < n) @(negedge clk);
    endtask

    function automatic int n_aref();
        int n = 0;
        for (int i = IREFS + 2; i < nlog; i++) if (lcmd[i] == C_AREF) n++;
        return n;
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog act=%0d exp=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int r, e, k, s, n, p, c, len;
        bit ok;
        repeat (3) @(negedge clk);
        chk(cke && dqm_hold && traffic_hold && !init_done && !req_valid, "R1 reset", {cke, dqm_hold, init_done, req_valid}, 4'b1100);
        rst = 1'b0;
        while (!init_done) @(negedge clk);
        r = cyc;
        // power-up order, addresses and spacing
        chk(lcmd[0] == C_PALL && lcyc[0] == STAB, "R2 first PALL cycle", lcyc[0], STAB);
        chk(laddr[0][10] == 1'b1, "R3 PALL A10", laddr[0], 12'h400);
        ok = 1'b1;
        for (int i = 1; i <= IREFS; i++) begin
            if (lcmd[i] != C_AREF || laddr[i] != 0) ok = 1'b0;
            if (lcyc[i] - lcyc[i-1] != ((i == 1) ? T_RP + 1 : T_RC + 1)) ok = 1'b0;
        end
        chk(ok, "R3 R4 init refreshes", lcyc[IREFS], lcyc[0] + T_RP + 1 + (IREFS - 1) * (T_RC + 1));
        chk(lcmd[IREFS+1] == C_MRS && laddr[IREFS+1] == MODE, "R3 mode load", laddr[IREFS+1], MODE);
        chk(lcyc[IREFS+1] - lcyc[IREFS] == T_RC + 1, "R4 gap before mode load", lcyc[IREFS+1] - lcyc[IREFS], T_RC + 1);
        chk(r == lcyc[IREFS+1] + T_MRD + 1 && !dqm_hold, "R5 init_done timing", r, lcyc[IREFS+1] + T_MRD + 1);

        // periodic refresh
        k = nlog;
        until_log(k + 1);
        e = lcyc[k];
        chk(lcmd[k] == C_AREF && e == r + INTERVAL, "R6 first refresh", e, r + INTERVAL);
        upto(e + T_RC);
        chk(traffic_hold, "R7 hold during refresh gap", traffic_hold, 1);
        upto(e + T_RC + 1);
        chk(!traffic_hold, "R7 hold release", traffic_hold, 0);
        until_log(k + 2);
        chk(lcyc[k+1] - e == INTERVAL, "R6 refresh period", lcyc[k+1] - e, INTERVAL);

        // refresh with an open bank
        all_idle = 1'b0;
        e = lcyc[k+1];
        until_log(k + 4);
        chk(lcmd[k+2] == C_PALL && lcyc[k+2] == e + INTERVAL && laddr[k+2][10], "R8 precharge first", lcyc[k+2], e + INTERVAL);
        chk(lcmd[k+3] == C_AREF && lcyc[k+3] == lcyc[k+2] + T_RP + 1, "R8 refresh after precharge", lcyc[k+3], lcyc[k+2] + T_RP + 1);

        // debt sweep over blocked windows
        for (int j = 0; j < 4; j++) begin
            len = (j == 0) ? INTERVAL / 2 : (j == 1) ? INTERVAL : (j == 2) ? 2 * INTERVAL : 3 * INTERVAL + 5;
            busy = 1'b1;
            repeat (len) @(negedge clk);
            busy = 1'b0;
            k = nlog;
            @(negedge clk);
            while (traffic_hold) @(negedge clk);
            c = cyc;
            ok = 1'b1;
            for (int i = k + 1; i < nlog; i++) if (lcyc[i] - lcyc[i-1] != T_RC + 1) ok = 1'b0;
            chk(ok, "R9 back-to-back spacing", nlog - k, len / INTERVAL);
            chk(n_aref() == (c - r) / INTERVAL, "R9 refresh count", n_aref(), (c - r) / INTERVAL);
        end

        // self-refresh entry and exit
        self_req = 1'b1;
        s = cyc;
        @(negedge clk);
        chk(!cke && lcmd[nlog-1] == C_SREF && lcyc[nlog-1] == s, "R10 self entry", lcyc[nlog-1], s);
        ok = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (cke || req_valid) ok = 1'b0;
        end
        chk(ok, "R10 cke held low, no requests", cke, 0);
        self_req = 1'b0;
        n = cyc;
        k = nlog;
        @(negedge clk);
        chk(cke, "R11 cke rises", cke, 1);
        ok = 1'b1;
        for (int i = 1; i <= T_XSR; i++) begin
            upto(n + i);
            if (req_valid || !traffic_hold) ok = 1'b0;
        end
        chk(ok, "R11 recovery window quiet", req_valid, 0);
        upto(n + T_XSR + 1);
        chk(!traffic_hold, "R11 hold drops after recovery", traffic_hold, 0);
        until_log(k + 1);
        chk(lcmd[k] == C_AREF && lcyc[k] == n + T_XSR + 1 + INTERVAL, "R11 refresh restart", lcyc[k], n + T_XSR + 1 + INTERVAL);

        // self-refresh request with an open bank
        @(negedge clk);
        while (traffic_hold) @(negedge clk);
        all_idle = 1'b0;
        self_req = 1'b1;
        p = cyc;
        k = nlog;
        until_log(k + 2);
        chk(lcmd[k] == C_PALL && lcyc[k] == p, "R12 precharge before entry", lcyc[k], p);
        chk(lcmd[k+1] == C_SREF && lcyc[k+1] == p + T_RP + 1, "R12 entry after precharge", lcyc[k+1], p + T_RP + 1);
        @(negedge clk);
        chk(!cke, "R10 cke low after entry", cke, 0);
        self_req = 1'b0;
        @(negedge clk);
        while (traffic_hold) @(negedge clk);
        chk(init_done && cke && !dqm_hold, "R5 state kept after exit", init_done, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule